// File: doc/BRIEF.md
# Selectable-Clock Up/Down Timer Counter

This block is a cyclic timer/counter whose register is 10 bits wide. Its active length can be set to 4, 6, 8 or 10 bits. A 3-bit select chooses one of eight clock sources. Six of them are prescaler taps. The other two come from external pins, and each pin can be marked as used without debouncing. All eight sources are sampled and synchronized into the system clock domain. The count then moves by one on each rising edge of the chosen source, upward or downward. Only the active low bits change, and the unused high bits hold their value.

Outside event-count mode, counting waits for a falling edge of the source that arrives while start is set, and begins on the next rising edge. This keeps the first period from being cut short by a clock that happened to be high when start was set. In event-count mode every rising edge after start counts.

A pin clock used without debouncing is first divided by two. The divided clock rises on the odd-numbered falling edges of the pin. In down mode the counter reloads the last written start value when it steps from zero. A one-cycle interrupt pulse flags each step that lands on the terminal value: all active bits set when counting up, all active bits clear when counting down.

Top module: `selcnt_timer`

## Requirements
- R1: `src_sel_i` picks source index `src_sel_i` of `src_clk_i`. Edges on any source that is not selected leave `count_o` unchanged.
- R2: `len_i` sets the active width: 0 gives 4 bits, 1 gives 6, 2 gives 8 and 3 gives 10. Counting steps change only the active low bits. The bits above them keep their value.
- R3: When `up_i`=0 the count goes down. A step that lands on an active value of zero is a roll-over. The step after that loads the active bits of the last written start value.
- R4: When `up_i`=1 the count goes up and wraps from all-ones to zero within the active bits. Landing on all-ones is a roll-over.
- R5: While counting is enabled, each rising edge of the selected source (after synchronization) changes the count by exactly one step.
- R6: When `evt_mode_i`=0 and `start_i` is raised, a rising edge that comes before any falling edge is not counted. The first rising edge after a falling edge seen while `start_i`=1 is counted, and so is every one after it.
- R7: When `start_i` is 0, the count holds. The falling-edge arming is cleared, so a later restart must again see a falling edge before it counts.
- R8: When `evt_mode_i`=1, every rising edge of the selected source while `start_i`=1 is counted, with no arming.
- R9: Source index 6 is pin A and index 7 is pin B. When the matching bit of `pin_raw_i` is 1 (bit 0 for A, bit 1 for B), the pin is divided by two. The count then advances only on the 1st, 3rd, 5th and later odd falling edges of the pin after start. When the bit is 0, the pin counts on each rising edge like a prescaler tap.
- R10: `irq_o` is high for exactly one system clock cycle per roll-over. It is high in the same cycle in which `count_o` first shows the terminal value.
- R11: A cycle with `load_i`=1 writes `load_val_i` to `count_o` on the next clock and stores it as the reload value. A load takes priority over a counting step.
- R12: After reset `count_o` is 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_clk_i | input | 8 | Candidate clock sources: indices 0-5 are prescaler taps, 6 is pin A, 7 is pin B |
| pin_raw_i | input | 2 | Per-pin flag that the pin is used without debouncing (bit 0 is A, bit 1 is B) |
| src_sel_i | input | 3 | Clock source select |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| len_i | input | 2 | Active length code (4/6/8/10 bits) |
| start_i | input | 1 | Counting enable |
| evt_mode_i | input | 1 | Event-count mode; bypasses start arming |
| load_i | input | 1 | Write strobe for the start value |
| load_val_i | input | 10 | Start value |
| count_o | output | 10 | Current count |
| irq_o | output | 1 | Roll-over pulse |

## Verification
A vector table runs each of the six prescaler taps with a different pairing of direction, length and start value. While it does, the next source index toggles in antiphase, so a wrong select or a leak from a neighbouring source shows up as an extra count. The table vectors start near zero or near all-ones with high bits set. This separates a correct length mask from a full-width wrap, and a reload of the start value from a wrap through the full range.

Vectors with event mode on and off differ by exactly one count. That difference tells the start arming apart from plain edge counting. Directed tests cover the following:
- a stop followed by a re-armed restart;
- the raw pin, counting on odd falling edges, against the debounced pin, counting on every rising edge;
- a load that wins over a step;
- the one-cycle interrupt width.

// File: rtl/selcnt_pkg.sv
package selcnt_pkg;

   typedef enum logic [1:0] {
      LEN_4  = 2'd0,
      LEN_6  = 2'd1,
      LEN_8  = 2'd2,
      LEN_10 = 2'd3
   } len_e;

   localparam int unsigned MIN_CNT_W = 10;

   function automatic int unsigned active_bits(input len_e len);
      return 4 + 2 * int'(len);
   endfunction

endpackage

// File: rtl/selcnt_clk_pick.sv
module selcnt_clk_pick #(
   parameter int unsigned N_SRC       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PIN_A_IDX   = 6,
   parameter int unsigned PIN_B_IDX   = 7,
   localparam int unsigned SEL_W      = $clog2(N_SRC)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_SRC-1:0] src_clk_i,
   input  logic [1:0]       pin_raw_i,
   input  logic [SEL_W-1:0] src_sel_i,
   input  logic             div_clr_i,
   output logic             eff_rise_o,
   output logic             eff_fall_o
);

   logic [N_SRC-1:0] synced;

   for (genvar s = 0; s < N_SRC; s++) begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chain <= '0;
         else         chain <= {chain[SYNC_STAGES-2:0], src_clk_i[s]};
      end
      assign synced[s] = chain[SYNC_STAGES-1];
   end

   logic sel_now, sel_prev, rise_raw, fall_raw, is_direct, div_q;

   assign sel_now  = synced[src_sel_i];
   assign rise_raw = sel_now & ~sel_prev;
   assign fall_raw = ~sel_now & sel_prev;

   always_comb begin
      is_direct = 1'b0;
      if (int'(src_sel_i) == int'(PIN_A_IDX)) is_direct = pin_raw_i[0];
      if (int'(src_sel_i) == int'(PIN_B_IDX)) is_direct = pin_raw_i[1];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_prev <= 1'b0;
         div_q    <= 1'b0;
      end else begin
         sel_prev <= sel_now;
         if (div_clr_i)                  div_q <= 1'b0;
         else if (is_direct && fall_raw) div_q <= ~div_q;
      end
   end

   assign eff_rise_o = is_direct ? (fall_raw & ~div_q) : rise_raw;
   assign eff_fall_o = is_direct ? (fall_raw &  div_q) : fall_raw;

endmodule

// File: rtl/selcnt_start_gate.sv
module selcnt_start_gate (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic evt_mode_i,
   input  logic eff_rise_i,
   input  logic eff_fall_i,
   output logic step_o
);

   logic armed_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         armed_q <= 1'b0;
      else if (!start_i)   armed_q <= 1'b0;
      else if (eff_fall_i) armed_q <= 1'b1;
   end

   assign step_o = start_i & eff_rise_i & (evt_mode_i | armed_q);

endmodule

// File: rtl/selcnt_core.sv
module selcnt_core
   import selcnt_pkg::*;
#(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             step_i,
   input  logic             up_i,
   input  logic [1:0]       len_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] count_o,
   output logic             irq_o
);

   logic [CNT_W-1:0] cnt_q, reload_q, mask, nxt, inc, dec;
   logic             irq_q, term_nxt;

   always_comb begin
      for (int i = 0; i < int'(CNT_W); i++)
         mask[i] = (i < int'(active_bits(len_e'(len_i))));
   end

   assign inc = cnt_q + 1'b1;
   assign dec = cnt_q - 1'b1;

   always_comb begin
      if (up_i)                     nxt = (cnt_q & ~mask) | (inc & mask);
      else if ((cnt_q & mask) == 0) nxt = (cnt_q & ~mask) | (reload_q & mask);
      else                          nxt = (cnt_q & ~mask) | (dec & mask);
      term_nxt = up_i ? ((nxt & mask) == mask) : ((nxt & mask) == '0);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q    <= '0;
         reload_q <= '0;
         irq_q    <= 1'b0;
      end else if (load_i) begin
         cnt_q    <= load_val_i;
         reload_q <= load_val_i;
         irq_q    <= 1'b0;
      end else if (step_i) begin
         cnt_q    <= nxt;
         irq_q    <= term_nxt;
      end else begin
         irq_q    <= 1'b0;
      end
   end

   assign count_o = cnt_q;
   assign irq_o   = irq_q;

endmodule

// File: rtl/selcnt_timer.sv
module selcnt_timer
   import selcnt_pkg::*;
#(
   parameter int unsigned CNT_W       = 10,
   parameter int unsigned N_SRC       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PIN_A_IDX   = 6,
   parameter int unsigned PIN_B_IDX   = 7,
   localparam int unsigned SEL_W      = $clog2(N_SRC)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_SRC-1:0] src_clk_i,
   input  logic [1:0]       pin_raw_i,
   input  logic [SEL_W-1:0] src_sel_i,
   input  logic             up_i,
   input  logic [1:0]       len_i,
   input  logic             start_i,
   input  logic             evt_mode_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] count_o,
   output logic             irq_o
);

   if (CNT_W < MIN_CNT_W) begin : g_bad_width
      $error("selcnt_timer: CNT_W must be at least 10");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("selcnt_timer: SYNC_STAGES must be at least 2");
   end
   if (PIN_A_IDX >= N_SRC || PIN_B_IDX >= N_SRC || PIN_A_IDX == PIN_B_IDX) begin : g_bad_pins
      $error("selcnt_timer: pin indices must be distinct and inside N_SRC");
   end

   logic eff_rise, eff_fall, step;

   selcnt_clk_pick #(
      .N_SRC      (N_SRC),
      .SYNC_STAGES(SYNC_STAGES),
      .PIN_A_IDX  (PIN_A_IDX),
      .PIN_B_IDX  (PIN_B_IDX)
   ) u_pick (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .src_clk_i (src_clk_i),
      .pin_raw_i (pin_raw_i),
      .src_sel_i (src_sel_i),
      .div_clr_i (~start_i),
      .eff_rise_o(eff_rise),
      .eff_fall_o(eff_fall)
   );

   selcnt_start_gate u_gate (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start_i),
      .evt_mode_i(evt_mode_i),
      .eff_rise_i(eff_rise),
      .eff_fall_i(eff_fall),
      .step_o    (step)
   );

   selcnt_core #(.CNT_W(CNT_W)) u_core (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .step_i    (step),
      .up_i      (up_i),
      .len_i     (len_i),
      .load_i    (load_i),
      .load_val_i(load_val_i),
      .count_o   (count_o),
      .irq_o     (irq_o)
   );

endmodule

// File: rtl/selcnt_timer_chk.sv
module selcnt_timer_chk #(
   parameter int unsigned CNT_W = 10
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             start_i,
   input logic             up_i,
   input logic [1:0]       len_i,
   input logic             load_i,
   input logic [CNT_W-1:0] load_val_i,
   input logic [CNT_W-1:0] count_o,
   input logic             irq_o
);

   function automatic logic [CNT_W-1:0] lmask(input logic [1:0] l);
      logic [CNT_W-1:0] m;
      for (int i = 0; i < int'(CNT_W); i++) m[i] = (i < 4 + 2 * int'(l));
      return m;
   endfunction

   p_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> count_o == $past(load_val_i));

   p_hold_stopped_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!start_i && !load_i) |=> $stable(count_o));

   p_high_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && len_i == 2'd0) |=> $stable(count_o[CNT_W-1:4]));

   p_irq_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |=> !irq_o);

   p_irq_terminal_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> ($past(up_i)
                 ? ((count_o & lmask($past(len_i))) == lmask($past(len_i)))
                 : ((count_o & lmask($past(len_i))) == '0)));

endmodule

bind selcnt_timer selcnt_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .start_i   (start_i),
   .up_i      (up_i),
   .len_i     (len_i),
   .load_i    (load_i),
   .load_val_i(load_val_i),
   .count_o   (count_o),
   .irq_o     (irq_o)
);

// File: tb/selcnt_timer_tb.sv
module selcnt_timer_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] src = '0;
   logic [1:0] pin_raw = 2'b00;
   logic [2:0] sel = '0;
   logic       up = 1'b0;
   logic [1:0] len = 2'd3;
   logic       start = 1'b0;
   logic       evt = 1'b0;
   logic       load = 1'b0;
   logic [9:0] load_val = '0;
   logic [9:0] count;
   logic       irq;

   int total = 0;
   int bad = 0;
   int irq_total = 0;
   int irq_base = 0;

   always #2 clk = ~clk;

   selcnt_timer u_dut (
      .clk_i(clk), .rst_ni(rst_n), .src_clk_i(src), .pin_raw_i(pin_raw),
      .src_sel_i(sel), .up_i(up), .len_i(len), .start_i(start),
      .evt_mode_i(evt), .load_i(load), .load_val_i(load_val),
      .count_o(count), .irq_o(irq)
   );

   always @(negedge clk) if (rst_n && irq) irq_total++;

   // fields: sel(3) up(1) len(2) evt(1) load(10) pulses(4) exp_cnt(10) exp_irq(2)
   localparam int NV = 7;
   localparam logic [32:0] VEC [NV] = '{
      {3'd0, 1'b0, 2'd3, 1'b1, 10'h005, 4'd3, 10'h002, 2'd0},
      {3'd1, 1'b0, 2'd0, 1'b1, 10'h0F3, 4'd3, 10'h0F0, 2'd1},
      {3'd2, 1'b0, 2'd0, 1'b1, 10'h0F3, 4'd5, 10'h0F2, 2'd1},
      {3'd3, 1'b1, 2'd1, 1'b1, 10'h27D, 4'd3, 10'h240, 2'd1},
      {3'd4, 1'b1, 2'd2, 1'b0, 10'h1FD, 4'd4, 10'h100, 2'd1},
      {3'd5, 1'b1, 2'd3, 1'b0, 10'h3FE, 4'd2, 10'h3FF, 2'd1},
      {3'd5, 1'b0, 2'd3, 1'b0, 10'h002, 4'd1, 10'h002, 2'd0}
   };

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   // one full period on source idx; noise source toggles in antiphase
   task automatic pulses(input int idx, input int n, input int noise);
      for (int p = 0; p < n; p++) begin
         src[idx] = 1'b1;
         if (noise >= 0) src[noise] = 1'b0;
         cycles(5);
         src[idx] = 1'b0;
         if (noise >= 0) src[noise] = 1'b1;
         cycles(5);
      end
      if (noise >= 0) src[noise] = 1'b0;
      cycles(5);
   endtask

   task automatic do_load(input logic [9:0] v);
      load_val = v;
      load = 1'b1;
      cycles(1);
      load = 1'b0;
      cycles(1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      cycles(3);
      chk("R12 count after reset", int'(count), 0);
      chk("R12 irq after reset", int'(irq), 0);
      rst_n = 1'b1;
      cycles(3);
      chk("R12 count idle", int'(count), 0);

      // table walk: R1 R2 R3 R4 R5 R6 R8 R10
      for (int v = 0; v < NV; v++) begin
         start = 1'b0;
         sel = VEC[v][32:30];
         up  = VEC[v][29];
         len = VEC[v][28:27];
         evt = VEC[v][26];
         cycles(2);
         do_load(VEC[v][25:16]);
         chk("R11 load value", int'(count), int'(VEC[v][25:16]));
         irq_base = irq_total;
         start = 1'b1;
         cycles(2);
         pulses(int'(VEC[v][32:30]), int'(VEC[v][15:12]), (int'(VEC[v][32:30]) + 1) % 8);
         chk($sformatf("R1/R2/R3/R4/R5/R6/R8 vec%0d count", v), int'(count), int'(VEC[v][11:2]));
         chk($sformatf("R10 vec%0d irq pulses", v), irq_total - irq_base, int'(VEC[v][1:0]));
      end

      // R7 stop freezes, restart re-arms
      start = 1'b0; sel = 3'd0; up = 1'b0; len = 2'd3; evt = 1'b1;
      cycles(2);
      do_load(10'd10);
      start = 1'b1; cycles(2);
      pulses(0, 2, -1);
      chk("R7 counted before stop", int'(count), 8);
      start = 1'b0; cycles(2);
      pulses(0, 3, -1);
      chk("R7 held while stopped", int'(count), 8);
      evt = 1'b0; start = 1'b1; cycles(2);
      pulses(0, 1, -1);
      chk("R7 R6 restart first rise ignored", int'(count), 8);
      pulses(0, 1, -1);
      chk("R7 R6 restart armed count", int'(count), 7);

      // R9 raw pin A halves, debounced pin B does not
      start = 1'b0; sel = 3'd6; up = 1'b1; evt = 1'b1; pin_raw = 2'b01;
      cycles(2);
      do_load(10'd0);
      start = 1'b1; cycles(2);
      pulses(6, 1, -1);
      chk("R9 raw pin first fall counts", int'(count), 1);
      pulses(6, 1, -1);
      chk("R9 raw pin second fall ignored", int'(count), 1);
      pulses(6, 2, -1);
      chk("R9 raw pin four pulses", int'(count), 2);
      start = 1'b0; sel = 3'd7;
      cycles(2);
      do_load(10'd0);
      start = 1'b1; cycles(2);
      pulses(7, 4, -1);
      chk("R9 debounced pin four pulses", int'(count), 4);

      // R10 R4 up wrap in 4-bit length with single-cycle irq
      start = 1'b0; sel = 3'd2; len = 2'd0; up = 1'b1; evt = 1'b1;
      cycles(2);
      do_load(10'h30E);
      irq_base = irq_total;
      start = 1'b1; cycles(2);
      pulses(2, 3, 3);
      chk("R4 R2 wrap keeps high bits", int'(count), 10'h301);
      chk("R10 one irq cycle per roll-over", irq_total - irq_base, 1);

      // R11 load wins over a simultaneous step
      src[2] = 1'b1;
      cycles(2);
      load_val = 10'h155; load = 1'b1;
      cycles(2);
      load = 1'b0;
      cycles(1);
      chk("R11 load priority", int'(count), 10'h155);
      src[2] = 1'b0;
      cycles(5);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule